// File: doc/BRIEF.md
# Shared JTAG Test Access Port with Auxiliary Handoff

This block is a JTAG test access port controller that shares one set of JTAG pins with up to four auxiliary TAP ports. While it owns the pins it runs the standard 16-state TAP state machine. It also runs a 4-bit instruction register and a single-bit bypass register. All of its own data scans go through the bypass register.

An access instruction hands the pins to one auxiliary port. From then on, the pin TMS and TDI reach that port and its TDO is driven out on the pin. The main state machine keeps following TMS throughout. This lets it see the point where the pins should come back: an Update-DR that was preceded by a Pause-DR in the same data scan.

Ports that are not selected get TMS and TDI held low, which parks them in Run-Test/Idle. The block runs entirely on a fast system clock. It synchronises TCK, TMS and TDI into that domain and acts on the TCK edges it detects. TCK must run below one quarter of the system clock rate.

Top module: `jtag_shared_tap`

## Requirements
- R1: While the system reset or the test reset is asserted, `tdo_oe` is 0, every bit of `aux_tms` and `aux_tdi` is 0, the main controller owns the pins and the current instruction is BYPASS.
- R2: The state machine follows the 16 standard TAP transitions on each TCK rising edge. Five rising edges with TMS at 1 reach Test-Logic-Reset from any state.
- R3: In Capture-IR the instruction shift register loads binary 0001. During Shift-IR its bit 0 appears on `tdo` first, and TDI enters at bit 3.
- R4: Every opcode outside 1000..1011, including 1111 (BYPASS) and unassigned values, uses the one-bit bypass register for data scans. Its first output bit is 0, and each later output bit is the TDI bit sampled one TCK earlier. A Pause-DR in such a scan has no effect on pin ownership.
- R5: After Update-IR loads opcode 1000, 1001, 1010 or 1011, the pins pass to auxiliary port 0, 1, 2 or 3. The handoff takes effect at the next TCK falling edge and not before.
- R6: While an auxiliary port owns the pins, its `aux_tms` and `aux_tdi` bits follow the `tms` and `tdi` pins. In Shift-IR and Shift-DR, `tdo` shows that port's `aux_tdo` bit.
- R7: Every auxiliary port that does not own the pins sees 0 on its `aux_tms` and `aux_tdi` bits.
- R8: Ownership returns to the main controller at the TCK falling edge after an Update-DR, provided Pause-DR was entered since the preceding Capture-DR. A data scan without Pause-DR leaves ownership unchanged.
- R9: `tdo_oe` is 1 only while the state machine is in Shift-IR or Shift-DR, and changes only on TCK falling edges. When it is 0 the pad treats TDO as high impedance.
- R10: Reaching Test-Logic-Reset, or asserting `trst_n`, returns the pins to the main controller and loads BYPASS as the current instruction.
- R11: TDI and TMS take effect on TCK rising edges. The main controller's `tdo` value changes only on TCK falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, more than four times the TCK rate |
| rst_n | input | 1 | Active-low asynchronous system reset |
| trst_n | input | 1 | Active-low asynchronous test reset |
| tck | input | 1 | Test clock pin, sampled by `clk` |
| tms | input | 1 | Test mode select pin |
| tdi | input | 1 | Test data input pin |
| tdo | output | 1 | Test data output value |
| tdo_oe | output | 1 | Output enable for the TDO pad |
| aux_tms | output | NAUX | Routed TMS, one bit per auxiliary port |
| aux_tdi | output | NAUX | Routed TDI, one bit per auxiliary port |
| aux_tdo | input | NAUX | TDO from each auxiliary port |

## Verification
The block is driven with full instruction scans and data scans. These use BYPASS, an unassigned opcode, and each of the four access opcodes. Comparing BYPASS with the unassigned opcode shows that both take the one-bit path. Each access opcode is checked to route only its own port.

Data scans are run both with and without a Pause-DR, in main mode and in auxiliary mode. This separates the handback condition from a plain Update-DR, and shows that a pause has no effect when no port is active. Ownership is also ended through five TMS ones and through `trst_n`, to show that both reclaim paths work from an active port.

The reference model is checked after every TCK rising edge and every falling edge. This catches a handoff that happens too early and a TDO that moves on the wrong edge.

// File: rtl/jtag_share_pkg.sv
package jtag_share_pkg;

  typedef enum logic [3:0] {
    TS_RESET  = 4'd0,
    TS_IDLE   = 4'd1,
    TS_SEL_DR = 4'd2,
    TS_CAP_DR = 4'd3,
    TS_SHF_DR = 4'd4,
    TS_EX1_DR = 4'd5,
    TS_PAU_DR = 4'd6,
    TS_EX2_DR = 4'd7,
    TS_UPD_DR = 4'd8,
    TS_SEL_IR = 4'd9,
    TS_CAP_IR = 4'd10,
    TS_SHF_IR = 4'd11,
    TS_EX1_IR = 4'd12,
    TS_PAU_IR = 4'd13,
    TS_EX2_IR = 4'd14,
    TS_UPD_IR = 4'd15
  } tap_state_e;

  // Next state of the test access port for one TCK rising edge.
  function automatic tap_state_e tap_next(input tap_state_e cur, input logic m);
    tap_state_e nxt;
    case (cur)
      TS_RESET:  nxt = m ? TS_RESET  : TS_IDLE;
      TS_IDLE:   nxt = m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: nxt = m ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nxt = m ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: nxt = m ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: nxt = m ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nxt = m ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nxt = m ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: nxt = m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: nxt = m ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: nxt = m ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: nxt = m ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: nxt = m ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nxt = m ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nxt = m ? TS_UPD_IR : TS_SHF_IR;
      TS_UPD_IR: nxt = m ? TS_SEL_DR : TS_IDLE;
      default:   nxt = TS_RESET;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/tck_edge_detect.sv
module tck_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tck,
  input  logic tms,
  input  logic tdi,
  output logic tms_s,
  output logic tdi_s,
  output logic tck_rise,
  output logic tck_fall
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] tck_q, tms_q, tdi_q;
  logic          tck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tck_q    <= '0;
      tms_q    <= '1;
      tdi_q    <= '1;
      tck_prev <= 1'b0;
    end else begin
      tck_q[0] <= tck;
      tms_q[0] <= tms;
      tdi_q[0] <= tdi;
      for (int k = 1; k < STAGES; k++) begin
        tck_q[k] <= tck_q[k-1];
        tms_q[k] <= tms_q[k-1];
        tdi_q[k] <= tdi_q[k-1];
      end
      tck_prev <= tck_q[LAST];
    end
  end

  assign tck_rise = tck_q[LAST] & ~tck_prev;
  assign tck_fall = ~tck_q[LAST] & tck_prev;
  assign tms_s    = tms_q[LAST];
  assign tdi_s    = tdi_q[LAST];
endmodule

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_share_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       tck_rise,
  input  logic       tms_s,
  output tap_state_e tap_state
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)       tap_state <= TS_RESET;
    else if (tck_rise) tap_state <= tap_next(tap_state, tms_s);
  end
endmodule

// File: rtl/ir_bypass_path.sv
module ir_bypass_path
  import jtag_share_pkg::*;
#(
  parameter int IR_W = 4
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            tck_rise,
  input  logic            tdi_s,
  input  tap_state_e      tap_state,
  input  logic            hold_update,
  input  logic            load_bypass,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] ir_cur,
  output logic            ir_updated,
  output logic            shift_bit
);
  localparam logic [IR_W-1:0] CAPTURE_VAL = IR_W'(1);
  localparam logic [IR_W-1:0] OP_BYPASS   = '1;

  logic byp_q;

  assign ir_updated = tck_rise && (tap_state == TS_UPD_IR) && !hold_update;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ir_sr  <= CAPTURE_VAL;
      ir_cur <= OP_BYPASS;
      byp_q  <= 1'b0;
    end else begin
      if (load_bypass)     ir_cur <= OP_BYPASS;
      else if (ir_updated) ir_cur <= ir_sr;
      if (tck_rise) begin
        case (tap_state)
          TS_CAP_IR: ir_sr <= CAPTURE_VAL;
          TS_SHF_IR: ir_sr <= {tdi_s, ir_sr[IR_W-1:1]};
          TS_CAP_DR: byp_q <= 1'b0;
          TS_SHF_DR: byp_q <= tdi_s;
          default: ;
        endcase
      end
    end
  end

  assign shift_bit = (tap_state == TS_SHF_IR) ? ir_sr[0] : byp_q;
endmodule

// File: rtl/aux_port_router.sv
module aux_port_router
  import jtag_share_pkg::*;
#(
  parameter int              NAUX     = 4,
  parameter int              IR_W     = 4,
  parameter logic [IR_W-1:0] AUX_BASE = IR_W'(8)
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            tck_rise,
  input  logic            tck_fall,
  input  tap_state_e      tap_state,
  input  logic [IR_W-1:0] ir_cur,
  input  logic            ir_updated,
  input  logic            tms,
  input  logic            tdi,
  input  logic [NAUX-1:0] aux_tdo,
  output logic [NAUX-1:0] owned,
  output logic            any_owned,
  output logic            release_now,
  output logic            aux_tdo_sel,
  output logic [NAUX-1:0] aux_tms,
  output logic [NAUX-1:0] aux_tdi
);
  logic [NAUX-1:0] hit;
  logic            any_hit;
  logic            grant_pend, rel_pend, pause_seen;

  for (genvar g = 0; g < NAUX; g++) begin : g_decode
    assign hit[g]     = (ir_cur == (AUX_BASE + IR_W'(g)));
    assign aux_tms[g] = owned[g] & tms;
    assign aux_tdi[g] = owned[g] & tdi;
  end

  assign any_hit     = |hit;
  assign any_owned   = |owned;
  assign release_now = tck_fall & rel_pend;
  assign aux_tdo_sel = |(owned & aux_tdo);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      owned      <= '0;
      grant_pend <= 1'b0;
      rel_pend   <= 1'b0;
      pause_seen <= 1'b0;
    end else if (tap_state == TS_RESET) begin
      owned      <= '0;
      grant_pend <= 1'b0;
      rel_pend   <= 1'b0;
      pause_seen <= 1'b0;
    end else begin
      if (tck_rise) begin
        if (ir_updated) grant_pend <= 1'b1;
        if (any_owned) begin
          if (tap_state == TS_CAP_DR) pause_seen <= 1'b0;
          if (tap_state == TS_PAU_DR) pause_seen <= 1'b1;
          if (tap_state == TS_UPD_DR && pause_seen) rel_pend <= 1'b1;
        end
      end
      if (tck_fall) begin
        if (grant_pend) begin
          grant_pend <= 1'b0;
          pause_seen <= 1'b0;
          if (any_hit) owned <= hit;
        end
        if (rel_pend) begin
          rel_pend <= 1'b0;
          owned    <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/jtag_shared_tap.sv
module jtag_shared_tap
  import jtag_share_pkg::*;
#(
  parameter int NAUX        = 4,
  parameter int IR_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trst_n,
  input  logic            tck,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_oe,
  output logic [NAUX-1:0] aux_tms,
  output logic [NAUX-1:0] aux_tdi,
  input  logic [NAUX-1:0] aux_tdo
);
  localparam logic [IR_W-1:0] AUX_BASE = IR_W'(1) << (IR_W - 1);

  logic            arst_n;
  logic            tms_s, tdi_s, tck_rise, tck_fall;
  tap_state_e      tap_state;
  logic [IR_W-1:0] ir_sr, ir_cur;
  logic            ir_updated, shift_bit;
  logic [NAUX-1:0] owned;
  logic            any_owned, release_now, aux_tdo_sel;
  logic            tdo_q;

  assign arst_n = rst_n & trst_n;

  tck_edge_detect #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi),
    .tms_s(tms_s), .tdi_s(tdi_s), .tck_rise(tck_rise), .tck_fall(tck_fall)
  );

  tap_fsm u_fsm (
    .clk(clk), .arst_n(arst_n), .tck_rise(tck_rise), .tms_s(tms_s),
    .tap_state(tap_state)
  );

  ir_bypass_path #(.IR_W(IR_W)) u_ir (
    .clk(clk), .arst_n(arst_n), .tck_rise(tck_rise), .tdi_s(tdi_s),
    .tap_state(tap_state), .hold_update(any_owned),
    .load_bypass((tap_state == TS_RESET) | release_now),
    .ir_sr(ir_sr), .ir_cur(ir_cur), .ir_updated(ir_updated),
    .shift_bit(shift_bit)
  );

  aux_port_router #(.NAUX(NAUX), .IR_W(IR_W), .AUX_BASE(AUX_BASE)) u_route (
    .clk(clk), .arst_n(arst_n), .tck_rise(tck_rise), .tck_fall(tck_fall),
    .tap_state(tap_state), .ir_cur(ir_cur), .ir_updated(ir_updated),
    .tms(tms), .tdi(tdi), .aux_tdo(aux_tdo),
    .owned(owned), .any_owned(any_owned), .release_now(release_now),
    .aux_tdo_sel(aux_tdo_sel), .aux_tms(aux_tms), .aux_tdi(aux_tdi)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      tdo_q  <= 1'b0;
      tdo_oe <= 1'b0;
    end else if (tck_fall) begin
      tdo_q  <= shift_bit;
      tdo_oe <= (tap_state == TS_SHF_IR) || (tap_state == TS_SHF_DR);
    end
  end

  assign tdo = any_owned ? aux_tdo_sel : tdo_q;
endmodule

// File: rtl/jtag_shared_tap_chk.sv
module jtag_shared_tap_chk
  import jtag_share_pkg::*;
#(
  parameter int NAUX = 4,
  parameter int IR_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trst_n,
  input logic            tck_rise,
  input logic            tck_fall,
  input tap_state_e      tap_state,
  input logic [NAUX-1:0] owned,
  input logic [NAUX-1:0] aux_tms,
  input logic            tdo_oe,
  input logic [IR_W-1:0] ir_sr,
  input logic [IR_W-1:0] ir_cur
);
  AST_OE_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n || !trst_n)
    !tck_fall |=> $stable(tdo_oe)); // R9
  AST_OE_FROM_SHIFT: assert property (@(posedge clk) disable iff (!rst_n || !trst_n)
    $rose(tdo_oe) |-> ($past(tap_state) == TS_SHF_IR || $past(tap_state) == TS_SHF_DR)); // R9
  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n || !trst_n)
    $onehot0(owned)); // R6
  AST_PARKED_TMS: assert property (@(posedge clk) disable iff (!rst_n || !trst_n)
    $onehot0(aux_tms)); // R7
  AST_HANDOFF_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n || !trst_n)
    (!tck_fall && tap_state != TS_RESET) |=> $stable(owned)); // R5
  AST_TLR_RECLAIM: assert property (@(posedge clk) disable iff (!rst_n || !trst_n)
    (tap_state == TS_RESET) |=> (owned == '0 && ir_cur == '1)); // R10
  AST_CAPTURE_IR: assert property (@(posedge clk) disable iff (!rst_n || !trst_n)
    (tck_rise && tap_state == TS_CAP_IR) |=> (ir_sr == IR_W'(1))); // R3
endmodule

bind jtag_shared_tap jtag_shared_tap_chk #(.NAUX(NAUX), .IR_W(IR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trst_n(trst_n), .tck_rise(tck_rise),
  .tck_fall(tck_fall), .tap_state(tap_state), .owned(owned),
  .aux_tms(aux_tms), .tdo_oe(tdo_oe), .ir_sr(ir_sr), .ir_cur(ir_cur)
);

// File: tb/tb_jtag_shared_tap.sv
module tb_jtag_shared_tap;
  localparam int NA = 4;
  localparam int HALF = 8;
  localparam int S_RESET = 0, S_IDLE = 1, S_SELDR = 2, S_CAPDR = 3, S_SHFDR = 4,
                 S_EX1DR = 5, S_PAUDR = 6, S_EX2DR = 7, S_UPDDR = 8, S_SELIR = 9,
                 S_CAPIR = 10, S_SHFIR = 11, S_EX1IR = 12, S_PAUIR = 13,
                 S_EX2IR = 14, S_UPDIR = 15;

  logic clk = 1'b0;
  logic rst_n, trst_n, tck, tms, tdi;
  logic tdo, tdo_oe;
  logic [NA-1:0] aux_tms, aux_tdi, stub_tdo;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  int       m_st, m_owner, m_pend;
  bit       m_pause, m_byp, m_tdo, m_oe;
  bit [3:0] m_irsr;

  // auxiliary stub state
  int       stub_st [NA];
  bit [7:0] stub_sr [NA];

  always #2 clk = ~clk;

  jtag_shared_tap dut (
    .clk(clk), .rst_n(rst_n), .trst_n(trst_n), .tck(tck), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe), .aux_tms(aux_tms), .aux_tdi(aux_tdi),
    .aux_tdo(stub_tdo)
  );

  function automatic int tnext(int s, bit m);
    case (s)
      S_RESET: return m ? S_RESET : S_IDLE;
      S_IDLE:  return m ? S_SELDR : S_IDLE;
      S_SELDR: return m ? S_SELIR : S_CAPDR;
      S_CAPDR: return m ? S_EX1DR : S_SHFDR;
      S_SHFDR: return m ? S_EX1DR : S_SHFDR;
      S_EX1DR: return m ? S_UPDDR : S_PAUDR;
      S_PAUDR: return m ? S_EX2DR : S_PAUDR;
      S_EX2DR: return m ? S_UPDDR : S_SHFDR;
      S_UPDDR: return m ? S_SELDR : S_IDLE;
      S_SELIR: return m ? S_RESET : S_CAPIR;
      S_CAPIR: return m ? S_EX1IR : S_SHFIR;
      S_SHFIR: return m ? S_EX1IR : S_SHFIR;
      S_EX1IR: return m ? S_UPDIR : S_PAUIR;
      S_PAUIR: return m ? S_EX2IR : S_PAUIR;
      S_EX2IR: return m ? S_UPDIR : S_SHFIR;
      default: return m ? S_SELDR : S_IDLE;
    endcase
  endfunction

  // stub auxiliary TAPs driven by the routed pins
  initial for (int i = 0; i < NA; i++) begin
    stub_st[i] = S_IDLE;
    stub_sr[i] = 8'hA5 ^ 8'(i * 37);
  end
  initial stub_tdo = '0;

  always @(posedge tck) begin
    for (int i = 0; i < NA; i++) begin
      if (stub_st[i] == S_CAPDR) stub_sr[i] = 8'hA5 ^ 8'(i * 37);
      else if (stub_st[i] == S_SHFDR) stub_sr[i] = {aux_tdi[i], stub_sr[i][7:1]};
      stub_st[i] = tnext(stub_st[i], aux_tms[i]);
    end
  end

  always @(negedge tck)
    for (int i = 0; i < NA; i++) stub_tdo[i] <= stub_sr[i][0];

  task automatic check_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = S_RESET; m_owner = -1; m_pend = -2; m_pause = 0;
    m_byp = 0; m_tdo = 0; m_oe = 0; m_irsr = 4'b0001;
  endtask

  task automatic model_rise();
    case (m_st)
      S_CAPIR: m_irsr = 4'b0001;
      S_SHFIR: m_irsr = {tdi, m_irsr[3:1]};
      S_CAPDR: m_byp = 0;
      S_SHFDR: m_byp = tdi;
      default: ;
    endcase
    if (m_st == S_UPDIR && m_owner < 0)
      m_pend = (m_irsr >= 4'd8 && m_irsr <= 4'd11) ? int'(m_irsr) - 8 : -2;
    if (m_owner >= 0) begin
      if (m_st == S_CAPDR) m_pause = 0;
      if (m_st == S_PAUDR) m_pause = 1;
      if (m_st == S_UPDDR && m_pause) m_pend = -1;
    end
    m_st = tnext(m_st, tms);
    if (m_st == S_RESET) begin
      m_owner = -1; m_pend = -2; m_pause = 0;
    end
  endtask

  task automatic model_fall();
    if (m_pend >= 0) begin m_owner = m_pend; m_pause = 0; end
    else if (m_pend == -1) m_owner = -1;
    m_pend = -2;
    m_oe  = (m_st == S_SHFIR) || (m_st == S_SHFDR);
    m_tdo = (m_st == S_SHFIR) ? m_irsr[0] : m_byp;
  endtask

  task automatic compare(bit after_rise);
    string tg;
    check_bit("R9", "tdo_oe", tdo_oe, m_oe);
    if (m_oe) begin
      if (m_owner >= 0) check_bit("R6", "tdo from aux port", tdo, stub_tdo[m_owner]);
      else begin
        tg = (m_st == S_SHFIR || m_st == S_EX1IR) ? "R3" : "R4";
        if (after_rise) tg = {tg, "/R11"};
        check_bit(tg, "tdo main", tdo, m_tdo);
      end
    end
    for (int i = 0; i < NA; i++) begin
      tg = (m_owner == i) ? "R6" : "R7";
      check_bit(tg, $sformatf("aux_tms[%0d]", i), aux_tms[i], (m_owner == i) ? tms : 1'b0);
      check_bit(tg, $sformatf("aux_tdi[%0d]", i), aux_tdi[i], (m_owner == i) ? tdi : 1'b0);
    end
  endtask

  task automatic half(bit rise);
    tck = rise;
    if (rise) model_rise(); else model_fall();
    repeat (5) @(posedge clk);
    repeat (HALF - 5) begin
      @(negedge clk);
      compare(rise);
    end
  endtask

  task automatic tcyc(bit m, bit d);
    tms = m; tdi = d;
    half(1'b1);
    half(1'b0);
  endtask

  task automatic go_tlr();
    repeat (5) tcyc(1'b1, 1'b0);
    tcyc(1'b0, 1'b0);
  endtask

  task automatic ir_scan(bit [3:0] op);
    tcyc(1, 0); tcyc(1, 0); tcyc(0, 0); tcyc(0, 0);
    for (int b = 0; b < 4; b++) tcyc(b == 3, op[b]);
    tcyc(1, 0); tcyc(0, 0);
  endtask

  task automatic dr_scan(bit [7:0] data, bit with_pause);
    tcyc(1, 0); tcyc(0, 0); tcyc(0, 0);
    for (int b = 0; b < 8; b++) tcyc(b == 7, data[b]);
    if (with_pause) begin
      tcyc(0, 0); tcyc(0, 0); tcyc(1, 0);
    end
    tcyc(1, 0); tcyc(0, 0);
  endtask

  task automatic expect_owner(int idx, string req);
    tdi = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NA; i++)
      check_bit(req, $sformatf("ownership probe aux_tdi[%0d]", i), aux_tdi[i], (i == idx));
    tdi = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    tck = 0; tms = 0; tdi = 0; rst_n = 0; trst_n = 0;
    model_reset();
    repeat (6) @(negedge clk);
    check_bit("R1", "tdo_oe in reset", tdo_oe, 1'b0);
    check_bit("R1", "aux_tms in reset", |aux_tms, 1'b0);
    tdi = 1;
    @(negedge clk);
    check_bit("R1", "aux_tdi in reset", |aux_tdi, 1'b0);
    tdi = 0;
    rst_n = 1; trst_n = 1;
    repeat (4) @(negedge clk);

    go_tlr();                        // R2
    ir_scan(4'hF);                   // R3 capture bits on tdo
    dr_scan(8'b1011_0010, 1'b0);     // R4 bypass
    ir_scan(4'h5);                   // unassigned opcode
    dr_scan(8'h3C, 1'b1);            // R4 pause in main mode
    expect_owner(-1, "R4");

    ir_scan(4'hA);
    expect_owner(2, "R5");
    dr_scan(8'h96, 1'b0);
    expect_owner(2, "R8");
    dr_scan(8'h5A, 1'b1);
    expect_owner(-1, "R8");

    ir_scan(4'h8);
    expect_owner(0, "R5");
    ir_scan(4'h3);
    expect_owner(0, "R6");
    tcyc(1, 0); tcyc(0, 0); tcyc(0, 1);
    check_bit("R9", "oe in Shift-DR", tdo_oe, 1'b1);
    repeat (5) tcyc(1, 0);
    check_bit("R2", "oe after five TMS ones", tdo_oe, 1'b0);
    tcyc(0, 0);
    expect_owner(-1, "R10");

    ir_scan(4'hB);
    expect_owner(3, "R5");
    trst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check_bit("R10", "tdo_oe under trst", tdo_oe, 1'b0);
    expect_owner(-1, "R10");
    trst_n = 1;
    repeat (3) @(negedge clk);
    tcyc(0, 0); tcyc(0, 0);

    ir_scan(4'h9);
    expect_owner(1, "R5");
    dr_scan(8'hC3, 1'b1);
    expect_owner(-1, "R8");
    ir_scan(4'hF);
    dr_scan(8'h71, 1'b0);
    expect_owner(-1, "R4");

    done = 1;
    finish_run();
  end
endmodule